// File: doc/BRIEF.md
# DTMF Tone-Pair Frequency Classifier

This block turns two already-limited, clock-synchronous square waves into a key decision. One wave carries the low-group tone of a dual-tone telephone signal and the other carries the high-group tone. For each wave the block counts reference-clock cycles between consecutive rising edges. It sorts every measured period into one of the four nominal tones of its group, using a tight accept window and a wider reject limit. A group is declared present once it has produced the same tone for several periods in a row.

When both groups are present at once, the block raises a signal-condition flag and drives the 4-bit code of the key. A column-four inhibit input removes the 1633 Hz tone from consideration. The code output is qualified by the flag. Downstream logic, such as a guard-time filter and an output latch, consumes the flag and the code.

Top module: `dtmf_pair_classifier`

## Requirements
- R1: While reset is high and in the first cycle after it, `sig_cond` is 0 and `key_code` is 0.
- R2: With both groups present, `key_code` is set by row (697, 770, 852, 941 Hz) and column (1209, 1336, 1477, 1633 Hz). The digits 1 to 9 give 0001 to 1001 in row-major order. Row 941 gives 1011 (star) with 1209, 1010 (zero) with 1336 and 1100 (hash) with 1477. Column 1633 gives 1101, 1110, 1111 and 0000 for the four rows in ascending order.
- R3: A tone that deviates from nominal by no more than 1.5% plus 2 Hz is accepted as that tone.
- R4: A tone that deviates from every nominal of its group by 3.5% or more never contributes to a raised flag.
- R5: A period that lies between the accept and reject limits of a tone changes nothing, so a group that is already present stays present with the same tone.
- R6: A group becomes present only after three consecutive measured periods fall on the same tone. The first edge after reset or after a stall starts a measurement and is not itself a measurement.
- R7: If a group sees no rising edge for longer than the reject-limit period of 697 Hz plus a quarter, that group is absent and the flag drops.
- R8: While `inhibit_col4` is high, a 1633 Hz high tone counts as absent, so none of the four fourth-column keys raises the flag. Other columns are unaffected.
- R9: `key_code` is 0000 whenever `sig_cond` is low.
- R10: `sig_cond` is high only if both groups were present in the previous cycle. A rejected period in either group drops it at once.
- R11: While `sig_cond` stays high, `key_code` does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock used as the period time base |
| rst | input | 1 | Synchronous active-high reset |
| lo_tone | input | 1 | Limited low-group tone, synchronous to clk |
| hi_tone | input | 1 | Limited high-group tone, synchronous to clk |
| inhibit_col4 | input | 1 | High: the 1633 Hz column is treated as not detected |
| sig_cond | output | 1 | Both groups carry a valid tone |
| key_code | output | 4 | Code of the detected key, 0000 when sig_cond is low |

## Verification
A run counter or candidate tone stuck in a wrong state shows at the ports as a flag that rises one measured period too early or too late, or as the wrong code. Either fault is visible within three periods of the slower group after a new key is applied. A hold band that wrongly resets the run drops the flag within one period of the hold-band input. A stale timer that never fires keeps the flag high after a tone stops, which shows one timeout after the last edge. Inhibit and the code gating act within one cycle, so they are sampled a few cycles after each change.

// File: rtl/dtmf_cls_pkg.sv
package dtmf_cls_pkg;

    localparam int NUM_GROUPS      = 2;
    localparam int TONES_PER_GROUP = 4;
    localparam int BIN_W           = $clog2(TONES_PER_GROUP);
    localparam int CODE_W          = 4;

    // tolerance bands in parts per thousand, plus an absolute slack for accept
    localparam int ACC_PERMILLE = 15;
    localparam int ACC_SLACK_HZ = 2;
    localparam int REJ_PERMILLE = 35;

    typedef enum logic [1:0] {
        VD_MISS = 2'd0,
        VD_NEAR = 2'd1,
        VD_HIT  = 2'd2
    } verdict_kind_e;

    typedef struct packed {
        verdict_kind_e         kind;
        logic [BIN_W-1:0]      bin;
    } verdict_t;

    function automatic int tone_hz(input int grp, input int idx);
        if (grp == 0) begin
            case (idx)
                0:       return 697;
                1:       return 770;
                2:       return 852;
                default: return 941;
            endcase
        end
        case (idx)
            0:       return 1209;
            1:       return 1336;
            2:       return 1477;
            default: return 1633;
        endcase
    endfunction

    function automatic longint div_up(input longint num, input longint den);
        return (num + den - 1) / den;
    endfunction

    // shortest period still accepted (highest accepted frequency)
    function automatic int acc_min_cycles(input int ref_hz, input int hz);
        return int'(div_up(longint'(ref_hz) * 1000,
                           longint'(hz) * (1000 + ACC_PERMILLE) + ACC_SLACK_HZ * 1000));
    endfunction

    // longest period still accepted (lowest accepted frequency)
    function automatic int acc_max_cycles(input int ref_hz, input int hz);
        return int'((longint'(ref_hz) * 1000) /
                    (longint'(hz) * (1000 - ACC_PERMILLE) - ACC_SLACK_HZ * 1000));
    endfunction

    // periods at or below this value are rejected
    function automatic int rej_lo_cycles(input int ref_hz, input int hz);
        return int'((longint'(ref_hz) * 1000) / (longint'(hz) * (1000 + REJ_PERMILLE)));
    endfunction

    // periods at or above this value are rejected
    function automatic int rej_hi_cycles(input int ref_hz, input int hz);
        return int'(div_up(longint'(ref_hz) * 1000, longint'(hz) * (1000 - REJ_PERMILLE)));
    endfunction

    function automatic int stale_cycles(input int ref_hz);
        return (rej_hi_cycles(ref_hz, tone_hz(0, 0)) * 5) / 4 + 1;
    endfunction

    function automatic logic [CODE_W-1:0] key_code_of(input logic [BIN_W-1:0] row,
                                                      input logic [BIN_W-1:0] col);
        int r;
        int c;
        r = int'(row);
        c = int'(col);
        if (c == 3) return CODE_W'(13 + r);
        if (r == 3) begin
            case (c)
                0:       return CODE_W'(11);
                1:       return CODE_W'(10);
                default: return CODE_W'(12);
            endcase
        end
        return CODE_W'(r * 3 + c + 1);
    endfunction

endpackage

// File: rtl/tone_period_meter.sv
module tone_period_meter #(
    parameter int PER_W = 13,
    parameter int STALE = 6653
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tone,
    output logic             meas_stb,
    output logic [PER_W-1:0] meas_per,
    output logic             stale
);
    localparam logic [PER_W-1:0] STALE_V = PER_W'(STALE);

    logic             tone_q;
    logic             armed_q;
    logic [PER_W-1:0] cnt_q;
    logic             rise;

    assign rise     = tone && !tone_q;
    assign meas_stb = rise && armed_q;
    assign meas_per = cnt_q;
    assign stale    = (cnt_q == STALE_V);

    always_ff @(posedge clk) begin
        if (rst) begin
            tone_q  <= 1'b0;
            armed_q <= 1'b0;
            cnt_q   <= '0;
        end else begin
            tone_q <= tone;
            if (rise) begin
                armed_q <= 1'b1;
                cnt_q   <= PER_W'(1);
            end else if (cnt_q != STALE_V) begin
                cnt_q <= cnt_q + PER_W'(1);
            end else begin
                armed_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/tone_bin_classifier.sv
module tone_bin_classifier
    import dtmf_cls_pkg::*;
#(
    parameter int REF_HZ = 3579545,
    parameter int GROUP  = 0,
    parameter int PER_W  = 13
) (
    input  logic [PER_W-1:0] per,
    output verdict_t         verdict
);
    logic [31:0]                per_ext;
    logic [TONES_PER_GROUP-1:0] hit;
    logic [TONES_PER_GROUP-1:0] near;

    assign per_ext = 32'(per);

    for (genvar b = 0; b < TONES_PER_GROUP; b++) begin : g_bin
        localparam int HZ = tone_hz(GROUP, b);
        localparam logic [31:0] AMIN = 32'(acc_min_cycles(REF_HZ, HZ));
        localparam logic [31:0] AMAX = 32'(acc_max_cycles(REF_HZ, HZ));
        localparam logic [31:0] RLO  = 32'(rej_lo_cycles(REF_HZ, HZ));
        localparam logic [31:0] RHI  = 32'(rej_hi_cycles(REF_HZ, HZ));
        assign hit[b]  = (per_ext >= AMIN) && (per_ext <= AMAX);
        assign near[b] = (per_ext > RLO) && (per_ext < RHI);
    end

    always_comb begin
        verdict.kind = VD_MISS;
        verdict.bin  = '0;
        for (int b = 0; b < TONES_PER_GROUP; b++) begin
            if (near[b]) begin
                verdict.kind = VD_NEAR;
                verdict.bin  = BIN_W'(b);
            end
        end
        for (int b = 0; b < TONES_PER_GROUP; b++) begin
            if (hit[b]) begin
                verdict.kind = VD_HIT;
                verdict.bin  = BIN_W'(b);
            end
        end
    end
endmodule

// File: rtl/tone_run_validator.sv
module tone_run_validator
    import dtmf_cls_pkg::*;
#(
    parameter int RUN_LEN = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             meas_stb,
    input  verdict_t         verdict,
    input  logic             stale,
    output logic             tone_ok,
    output logic [BIN_W-1:0] tone_bin
);
    localparam int RUN_W = $clog2(RUN_LEN + 1);
    localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(RUN_LEN);

    logic [RUN_W-1:0] run_q;
    logic [RUN_W-1:0] run_inc;
    logic [BIN_W-1:0] cand_q;
    logic             ok_q;
    logic             same;

    assign same     = (run_q != '0) && (verdict.bin == cand_q);
    assign run_inc  = (run_q == RUN_MAX) ? RUN_MAX : run_q + RUN_W'(1);
    assign tone_ok  = ok_q;
    assign tone_bin = cand_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= '0;
            cand_q <= '0;
            ok_q   <= 1'b0;
        end else if (stale) begin
            run_q <= '0;
            ok_q  <= 1'b0;
        end else if (meas_stb) begin
            case (verdict.kind)
                VD_HIT: begin
                    if (same) begin
                        run_q <= run_inc;
                        ok_q  <= (run_inc == RUN_MAX);
                    end else begin
                        cand_q <= verdict.bin;
                        run_q  <= RUN_W'(1);
                        ok_q   <= (RUN_LEN == 1);
                    end
                end
                VD_NEAR: begin
                    run_q <= run_q;
                end
                default: begin
                    run_q <= '0;
                    ok_q  <= 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/dtmf_pair_classifier.sv
module dtmf_pair_classifier
    import dtmf_cls_pkg::*;
#(
    parameter int REF_HZ  = 3579545,
    parameter int RUN_LEN = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lo_tone,
    input  logic              hi_tone,
    input  logic              inhibit_col4,
    output logic              sig_cond,
    output logic [CODE_W-1:0] key_code
);
    localparam int STALE = stale_cycles(REF_HZ);
    localparam int PER_W = $clog2(STALE + 2);

    logic [NUM_GROUPS-1:0]            tone_in;
    logic [NUM_GROUPS-1:0]            grp_valid;
    logic [NUM_GROUPS-1:0][BIN_W-1:0] grp_bin;
    logic                             hi_ok;
    logic                             pair_ok;
    logic                             flag_q;
    logic [CODE_W-1:0]                code_q;

    assign tone_in = {hi_tone, lo_tone};

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        logic             stb;
        logic [PER_W-1:0] per;
        logic             stale;
        verdict_t         vd;

        tone_period_meter #(.PER_W(PER_W), .STALE(STALE)) u_meter (
            .clk      (clk),
            .rst      (rst),
            .tone     (tone_in[g]),
            .meas_stb (stb),
            .meas_per (per),
            .stale    (stale)
        );

        tone_bin_classifier #(.REF_HZ(REF_HZ), .GROUP(g), .PER_W(PER_W)) u_class (
            .per     (per),
            .verdict (vd)
        );

        tone_run_validator #(.RUN_LEN(RUN_LEN)) u_valid (
            .clk      (clk),
            .rst      (rst),
            .meas_stb (stb),
            .verdict  (vd),
            .stale    (stale),
            .tone_ok  (grp_valid[g]),
            .tone_bin (grp_bin[g])
        );
    end

    assign hi_ok   = grp_valid[1] && !(inhibit_col4 && grp_bin[1] == BIN_W'(3));
    assign pair_ok = grp_valid[0] && hi_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
            code_q <= '0;
        end else begin
            flag_q <= pair_ok;
            code_q <= pair_ok ? key_code_of(grp_bin[0], grp_bin[1]) : '0;
        end
    end

    assign sig_cond = flag_q;
    assign key_code = code_q;
endmodule

// File: rtl/dtmf_pair_classifier_chk.sv
module dtmf_pair_classifier_chk (
    input logic       clk,
    input logic       rst,
    input logic       inhibit_col4,
    input logic       sig_cond,
    input logic [3:0] key_code,
    input logic       lo_valid,
    input logic       hi_valid,
    input logic [1:0] hi_bin
);
    p_code_gated_r9: assert property (@(posedge clk) disable iff (rst)
        !sig_cond |-> key_code == 4'd0);

    p_pair_needed_r10: assert property (@(posedge clk) disable iff (rst)
        sig_cond |-> $past(lo_valid && hi_valid));

    p_col4_blocked_r8: assert property (@(posedge clk) disable iff (rst)
        sig_cond |-> !$past(inhibit_col4 && hi_bin == 2'd3));

    p_code_steady_r11: assert property (@(posedge clk) disable iff (rst)
        (sig_cond && $past(sig_cond)) |-> $stable(key_code));
endmodule

bind dtmf_pair_classifier dtmf_pair_classifier_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .inhibit_col4 (inhibit_col4),
    .sig_cond     (sig_cond),
    .key_code     (key_code),
    .lo_valid     (grp_valid[0]),
    .hi_valid     (grp_valid[1]),
    .hi_bin       (grp_bin[1])
);

// File: tb/dtmf_pair_classifier_test.sv
module dtmf_pair_classifier_test;
    localparam int REF = 357954;

    // {row, col, code}
    localparam logic [7:0] VEC [16] = '{
        {2'd0, 2'd0, 4'b0001}, {2'd0, 2'd1, 4'b0010}, {2'd0, 2'd2, 4'b0011},
        {2'd1, 2'd0, 4'b0100}, {2'd1, 2'd1, 4'b0101}, {2'd1, 2'd2, 4'b0110},
        {2'd2, 2'd0, 4'b0111}, {2'd2, 2'd1, 4'b1000}, {2'd2, 2'd2, 4'b1001},
        {2'd3, 2'd1, 4'b1010}, {2'd3, 2'd0, 4'b1011}, {2'd3, 2'd2, 4'b1100},
        {2'd0, 2'd3, 4'b1101}, {2'd1, 2'd3, 4'b1110}, {2'd2, 2'd3, 4'b1111},
        {2'd3, 2'd3, 4'b0000}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       lo_tone = 1'b0;
    logic       hi_tone = 1'b0;
    logic       inhibit_col4 = 1'b0;
    logic       sig_cond;
    logic [3:0] key_code;

    int lo_per = 0;
    int hi_per = 0;
    int tests_run = 0;
    int tests_failed = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    dtmf_pair_classifier #(.REF_HZ(REF)) uut (
        .clk          (clk),
        .rst          (rst),
        .lo_tone      (lo_tone),
        .hi_tone      (hi_tone),
        .inhibit_col4 (inhibit_col4),
        .sig_cond     (sig_cond),
        .key_code     (key_code)
    );

    always begin
        if (lo_per == 0) begin
            lo_tone = 1'b0;
            @(negedge clk);
        end else begin
            int p;
            p = lo_per;
            lo_tone = 1'b1;
            repeat (p / 2) @(negedge clk);
            lo_tone = 1'b0;
            repeat (p - p / 2) @(negedge clk);
        end
    end

    always begin
        if (hi_per == 0) begin
            hi_tone = 1'b0;
            @(negedge clk);
        end else begin
            int p;
            p = hi_per;
            hi_tone = 1'b1;
            repeat (p / 2) @(negedge clk);
            hi_tone = 1'b0;
            repeat (p - p / 2) @(negedge clk);
        end
    end

    function automatic int row_hz(input int r);
        case (r)
            0: return 697;
            1: return 770;
            2: return 852;
            default: return 941;
        endcase
    endfunction

    function automatic int col_hz(input int c);
        case (c)
            0: return 1209;
            1: return 1336;
            2: return 1477;
            default: return 1633;
        endcase
    endfunction

    function automatic int nom(input int hz);
        return (REF + hz / 2) / hz;
    endfunction

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_out(input string tag, input logic exp_flag, input logic [3:0] exp_code);
        tests_run++;
        if (sig_cond !== exp_flag || key_code !== exp_code) begin
            tests_failed++;
            $display("FAIL %s: flag/code got %0b/%04b expected %0b/%04b",
                     tag, sig_cond, key_code, exp_flag, exp_code);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            tests_failed++;
            $display("FAIL watchdog: got no completion expected completion");
            $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        wait_cyc(4);
        expect_out("R1 during reset", 1'b0, 4'd0);
        rst = 1'b0;
        @(negedge clk);
        expect_out("R1 after reset", 1'b0, 4'd0);

        // R6: three periods needed from idle; R9 code gated meanwhile
        lo_per = nom(697);
        hi_per = nom(1209);
        wait_cyc(1400);
        expect_out("R6 two periods only / R9", 1'b0, 4'd0);
        wait_cyc(900);
        expect_out("R6 three periods", 1'b1, 4'b0001);

        // R2: all sixteen keys
        for (int i = 0; i < 16; i++) begin
            logic [7:0] v;
            v = VEC[i];
            lo_per = nom(row_hz(int'(v[7:6])));
            hi_per = nom(col_hz(int'(v[5:4])));
            wait_cyc(4000);
            expect_out($sformatf("R2 key vector %0d", i), 1'b1, v[3:0]);
        end

        // R8: inhibit on fourth column
        lo_per = nom(697);
        hi_per = nom(1633);
        wait_cyc(4000);
        expect_out("R8 col4 allowed", 1'b1, 4'b1101);
        inhibit_col4 = 1'b1;
        wait_cyc(5);
        expect_out("R8 col4 inhibited / R9", 1'b0, 4'd0);
        inhibit_col4 = 1'b0;
        wait_cyc(5);
        expect_out("R8 inhibit released", 1'b1, 4'b1101);
        inhibit_col4 = 1'b1;
        hi_per = nom(1477);
        wait_cyc(4000);
        expect_out("R8 other column unaffected", 1'b1, 4'b0011);
        inhibit_col4 = 1'b0;

        // R7: both tones stop
        lo_per = 0;
        hi_per = 0;
        wait_cyc(1500);
        expect_out("R7 timeout both", 1'b0, 4'd0);

        // R3: accepted near the window edge
        lo_per = 520;
        hi_per = 300;
        wait_cyc(4000);
        expect_out("R3 accept edge", 1'b1, 4'b0001);

        // R5: hold band keeps decision; R11 code steady
        lo_per = 528;
        for (int k = 0; k < 4; k++) begin
            wait_cyc(800);
            expect_out("R5 hold band / R11", 1'b1, 4'b0001);
        end

        // R10 / R4: rejected period drops the flag
        lo_per = 540;
        wait_cyc(1300);
        expect_out("R10 reject drops flag", 1'b0, 4'd0);
        wait_cyc(3000);
        expect_out("R4 low reject stays off", 1'b0, 4'd0);

        lo_per = nom(697);
        hi_per = 312;
        wait_cyc(3000);
        expect_out("R4 high reject", 1'b0, 4'd0);

        // R7: one group stalls
        hi_per = nom(1209);
        wait_cyc(3000);
        expect_out("R7 restored", 1'b1, 4'b0001);
        lo_per = 0;
        wait_cyc(1400);
        expect_out("R7 low stall", 1'b0, 4'd0);

        // R1: reset mid-tone clears outputs
        lo_per = nom(852);
        wait_cyc(4000);
        expect_out("R2 key 7 before reset", 1'b1, 4'b0111);
        rst = 1'b1;
        wait_cyc(3);
        expect_out("R1 reset while active", 1'b0, 4'd0);
        rst = 1'b0;
        @(negedge clk);
        expect_out("R1 first cycle after reset", 1'b0, 4'd0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end
endmodule